// File: doc/BRIEF.md
# Data EEPROM Control Register Unit

This block is the register front end of a small on-chip data EEPROM. A CPU reaches it over a simple register bus with a 2-bit address, write data, a write strobe, a read strobe and combinational read data. It holds four registers: a control register (address 0), an address register (address 1), a data register (address 2) and an unlock register (address 3). The unlock register exists only as a decode: it captures nothing and reads back as zero. A one-cycle read copies the addressed byte of an internal byte array into the data register. A timed write stores the data register into the array. The write only starts after a two-byte unlock sequence, and it lasts `WR_CYCLES` clocks.

The operation sequencer has three states. `OP_IDLE` goes to `OP_READ` on an accepted read request. `OP_READ` always returns to `OP_IDLE` after one cycle. `OP_IDLE` goes to `OP_WRITE` on an accepted write start. `OP_WRITE` returns to `OP_IDLE` on the final counted cycle, which is the commit. A warm reset also returns it to `OP_IDLE`, and that is the abort. The unlock tracker has three states. A write of 0x55 to the unlock register moves it from any state to `UL_GOT55`. A write of 0xAA while in `UL_GOT55` moves it to `UL_ARMED`. Every other bus write, including the control write that consumes the arming, sends it back to `UL_IDLE`.

There are three reset inputs, all active low and sampled on the clock. Power-on reset `por_n` clears every register. External reset `ext_rst_n` and watchdog reset `wdt_rst_n` are both warm resets. A warm reset cancels operations and clears write enable, but it keeps the address and data registers so that an aborted write can be retried. A write-complete flag is output as `wdone`. Only the `wdone_clr` input clears it.

Top module: `eeprom_ctl_unit`

## Requirements
- R1: After power-on reset the control, address and data registers read 0x00 and `wdone` is 0.
- R2: Control register bits 7:4 always read 0. The unlock register (address 3) always reads 0x00.
- R3: Writing the control register with bit 0 (read start) set while idle makes bit 0 read 1 for one cycle. At the next clock the data register holds the array byte at the address register, and bit 0 reads 0.
- R4: Writing 0 to control bit 1 (write busy) or bit 0 has no effect: a write in progress keeps bit 1 at 1.
- R5: Setting control bit 1 starts a write only if bit 2 (write enable) is already 1. Without that, bit 1 stays 0 and the array is unchanged.
- R6: A write starts only if the two bus writes just before the control write were 0x55 and then 0xAA to address 3. Any other bus write between them cancels the sequence.
- R7: Bit 1 reads 1 for exactly `WR_CYCLES` cycles after the start. The data register byte is then stored at the held address, and bit 1 clears.
- R8: `wdone` sets on the cycle the write commits and holds until `wdone_clr`. If the commit and `wdone_clr` fall in the same cycle, the flag ends up set.
- R9: A warm reset (external or watchdog) during a write, including on its final cycle, aborts it. The array is not written, control bit 3 (error) sets, bits 2 and 1 clear, the address and data registers are kept, and `wdone` does not set.
- R10: A warm reset while idle clears bit 2 but leaves bit 3 and the address and data registers unchanged.
- R11: Power-on reset clears bits 3 and 2 even when they were set.
- R12: A read request while a write is in progress is ignored: bit 0 stays 0 and the data register is unchanged.
- R13: Bus writes to the address and data registers while a write is in progress are ignored.
- R14: Bit 3 is readable and writable by software through control writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| ext_rst_n | input | 1 | External warm reset, active low |
| wdt_rst_n | input | 1 | Watchdog warm reset, active low |
| bus_addr | input | 2 | Register select: 0 control, 1 address, 2 data, 3 unlock |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 8 | Read data |
| wdone_clr | input | 1 | Clears the write-complete flag |
| wdone | output | 1 | Write-complete flag |

## Verification
Two things can land on the edge where a timed write commits: a warm reset, and a software clear of the completion flag. Each is provoked on the bench by counting clocks from the write start and asserting the reset or the clear so that it is sampled exactly at commit edge `WR_CYCLES`. For the reset, the array byte must keep its old value, the error bit must set and the flag must stay low. For the clear, the flag must read 1 afterwards. A read request and a register write issued in the middle of a write are also judged: each must have no effect on the busy bit, the read bit or the held registers.

// File: rtl/eeprom_ctl_pkg.sv
package eeprom_ctl_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_state_t;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_GOT55 = 2'd1,
        UL_ARMED = 2'd2
    } unl_state_t;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_ADDR = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;
    localparam logic [1:0] REG_UNLK = 2'd3;

    localparam logic [7:0] UNLK_KEY1 = 8'h55;
    localparam logic [7:0] UNLK_KEY2 = 8'hAA;

    localparam int CTL_RD  = 0;
    localparam int CTL_WR  = 1;
    localparam int CTL_WEN = 2;
    localparam int CTL_ERR = 3;

endpackage

// File: rtl/ee_unlock_seq.sv
module ee_unlock_seq
    import eeprom_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       we,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic       armed
);

    unl_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (clr) state_q <= UL_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (we) begin
            if (addr == REG_UNLK && wdata == UNLK_KEY1)
                state_d = UL_GOT55;
            else if (addr == REG_UNLK && wdata == UNLK_KEY2 && state_q == UL_GOT55)
                state_d = UL_ARMED;
            else
                state_d = UL_IDLE;
        end
    end

    always_comb begin
        unique case (state_q)
            UL_ARMED: armed = 1'b1;
            default:  armed = 1'b0;
        endcase
    end

endmodule

// File: rtl/ee_op_fsm.sv
module ee_op_fsm
    import eeprom_ctl_pkg::*;
#(
    parameter int WR_CYCLES = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic warm,
    input  logic start_rd,
    input  logic start_wr,
    output logic rd_act,
    output logic busy,
    output logic commit
);

    localparam int CW = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WR_CYCLES - 1);

    op_state_t      state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic           at_last;

    assign at_last = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!por_n || warm) begin
            state_q <= OP_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == OP_WRITE && !at_last) cnt_q <= cnt_q + 1'b1;
            else                                 cnt_q <= '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OP_IDLE: begin
                if (start_wr)      state_d = OP_WRITE;
                else if (start_rd) state_d = OP_READ;
            end
            OP_READ:  state_d = OP_IDLE;
            OP_WRITE: if (at_last) state_d = OP_IDLE;
            default:  state_d = OP_IDLE;
        endcase
    end

    always_comb begin
        rd_act = 1'b0;
        busy   = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            OP_READ:  rd_act = 1'b1;
            OP_WRITE: begin
                busy   = 1'b1;
                commit = at_last && !warm && por_n;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ee_byte_array.sv
module ee_byte_array #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/eeprom_ctl_unit.sv
module eeprom_ctl_unit
    import eeprom_ctl_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int WR_CYCLES = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       ext_rst_n,
    input  logic       wdt_rst_n,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_we,
    input  logic       bus_re,
    output logic [7:0] bus_rdata,
    input  logic       wdone_clr,
    output logic       wdone
);

    localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

    logic          warm_rst;
    logic          armed, rd_act, busy, commit;
    logic          start_rd, start_wr;
    logic          err_q, wen_q, done_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q, arr_rdata;
    logic          ctl_we;

    assign warm_rst = !ext_rst_n || !wdt_rst_n;
    assign ctl_we   = bus_we && bus_addr == REG_CTRL;
    assign start_wr = ctl_we && bus_wdata[CTL_WR] && wen_q && armed && !busy && !rd_act;
    assign start_rd = ctl_we && bus_wdata[CTL_RD] && !busy && !rd_act && !start_wr;

    ee_unlock_seq u_unlock (
        .clk   (clk),
        .clr   (!por_n || warm_rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .armed (armed)
    );

    ee_op_fsm #(.WR_CYCLES(WR_CYCLES)) u_fsm (
        .clk      (clk),
        .por_n    (por_n),
        .warm     (warm_rst),
        .start_rd (start_rd && !warm_rst),
        .start_wr (start_wr && !warm_rst),
        .rd_act   (rd_act),
        .busy     (busy),
        .commit   (commit)
    );

    ee_byte_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk   (clk),
        .we    (commit),
        .waddr (addr_q),
        .wdata (data_q),
        .raddr (addr_q),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (!por_n) begin
            err_q  <= 1'b0;
            wen_q  <= 1'b0;
            done_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (warm_rst) begin
            wen_q <= 1'b0;
            if (busy) err_q <= 1'b1;
            if (wdone_clr) done_q <= 1'b0;
        end else begin
            if (ctl_we) begin
                err_q <= bus_wdata[CTL_ERR];
                wen_q <= bus_wdata[CTL_WEN];
            end
            if (commit)         done_q <= 1'b1;
            else if (wdone_clr) done_q <= 1'b0;
            if (bus_we && bus_addr == REG_ADDR && !busy)
                addr_q <= bus_wdata[AW-1:0];
            if (rd_act)
                data_q <= arr_rdata;
            else if (bus_we && bus_addr == REG_DATA && !busy)
                data_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_re) begin
            unique case (bus_addr)
                REG_CTRL: bus_rdata = {4'b0000, err_q, wen_q, busy, rd_act};
                REG_ADDR: bus_rdata = 8'(addr_q);
                REG_DATA: bus_rdata = data_q;
                REG_UNLK: bus_rdata = 8'h00;
                default:  bus_rdata = 8'h00;
            endcase
        end
    end

    assign wdone = done_q;

endmodule

// File: rtl/eeprom_ctl_chk.sv
module eeprom_ctl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       warm,
    input logic       busy,
    input logic       commit,
    input logic       rd_act,
    input logic       err,
    input logic       wen,
    input logic [7:0] data_q,
    input logic       bus_we,
    input logic       bus_re,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       done
);

    // R2
    ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_re && bus_addr == 2'd0) |-> (bus_rdata[7:4] == 4'h0));

    // R4
    busy_holds_chk: assert property (@(posedge clk) disable iff (!por_n)
        (busy && !commit && !warm) |=> busy);

    // R8
    done_after_commit_chk: assert property (@(posedge clk) disable iff (!por_n)
        commit |=> done);

    // R9
    abort_sets_err_chk: assert property (@(posedge clk) disable iff (!por_n)
        (busy && warm) |=> (err && !wen && !busy));

    // R11
    por_clears_chk: assert property (@(posedge clk)
        !por_n |=> (!err && !wen && !busy && !rd_act));

    // R12
    rd_ignored_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
        (busy && bus_we && bus_addr == 2'd0 && bus_wdata[0]) |=> !rd_act);

    // R13
    data_held_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
        (busy && bus_we && bus_addr == 2'd2) |=> $stable(data_q));

endmodule

bind eeprom_ctl_unit eeprom_ctl_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .warm      (warm_rst),
    .busy      (busy),
    .commit    (commit),
    .rd_act    (rd_act),
    .err       (err_q),
    .wen       (wen_q),
    .data_q    (data_q),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .done      (done_q)
);

// File: tb/eeprom_ctl_unit_tb.sv
`timescale 1ns/1ps
module eeprom_ctl_unit_tb;

    localparam int WRC = 16;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, ext_rst_n = 1'b1, wdt_rst_n = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0, bus_re = 1'b0, wdone_clr = 1'b0;
    logic [7:0] bus_rdata;
    logic       wdone;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    eeprom_ctl_unit #(.DEPTH(16), .WR_CYCLES(WRC)) u_dut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdt_rst_n(wdt_rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .wdone_clr(wdone_clr), .wdone(wdone)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a; bus_re = 1'b1;
        #0.5;
        v = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic start_write(input logic [3:0] a, input logic [7:0] d);
        wr(2'd1, 8'(a));
        wr(2'd2, d);
        wr(2'd0, 8'h04);
        wr(2'd3, 8'h55);
        wr(2'd3, 8'hAA);
        wr(2'd0, 8'h06);
    endtask

    task automatic array_byte(input logic [3:0] a, output logic [7:0] v);
        wr(2'd1, 8'(a));
        wr(2'd0, 8'h01);
        @(negedge clk);
        rd(2'd2, v);
    endtask

    task automatic t_reset;
        rd(2'd0, rv); chk_eq("R1 ctrl after por", rv, 8'h00);
        rd(2'd1, rv); chk_eq("R1 addr after por", rv, 8'h00);
        rd(2'd2, rv); chk_eq("R1 data after por", rv, 8'h00);
        chk_eq("R1 wdone after por", wdone, 0);
    endtask

    task automatic t_upper_bits;
        wr(2'd0, 8'hF4);
        rd(2'd0, rv); chk_eq("R2 ctrl upper bits", rv, 8'h04);
        wr(2'd3, 8'h55);
        rd(2'd3, rv); chk_eq("R2 unlock reads zero", rv, 8'h00);
        wr(2'd0, 8'h08);
        rd(2'd0, rv); chk_eq("R14 err bit writable", rv, 8'h08);
        wr(2'd0, 8'h00);
        rd(2'd0, rv); chk_eq("R14 err bit clearable", rv, 8'h00);
    endtask

    task automatic t_full_write;
        start_write(4'd5, 8'h3C);
        wait_cyc(WRC - 1);
        rd(2'd0, rv); chk_eq("R7 busy on last cycle", rv[1], 1);
        chk_eq("R8 wdone before commit", wdone, 0);
        @(negedge clk);
        rd(2'd0, rv); chk_eq("R7 busy clears after WR_CYCLES", rv[1], 0);
        chk_eq("R8 wdone after commit", wdone, 1);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h05);
        rd(2'd0, rv); chk_eq("R3 read bit visible", rv[0], 1);
        @(negedge clk);
        rd(2'd0, rv); chk_eq("R3 read bit self clears", rv[0], 0);
        rd(2'd2, rv); chk_eq("R3/R7 array byte loaded", rv, 8'h3C);
    endtask

    task automatic t_no_enable;
        wr(2'd1, 8'd5); wr(2'd2, 8'h99);
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h55); wr(2'd3, 8'hAA);
        wr(2'd0, 8'h02);
        rd(2'd0, rv); chk_eq("R5 no start without enable", rv[1], 0);
        wait_cyc(WRC + 2);
        array_byte(4'd5, rv); chk_eq("R5 array unchanged", rv, 8'h3C);
    endtask

    task automatic t_broken_unlock;
        wr(2'd2, 8'h99);
        wr(2'd0, 8'h04);
        wr(2'd3, 8'h55);
        wr(2'd2, 8'h99);
        wr(2'd3, 8'hAA);
        wr(2'd0, 8'h06);
        rd(2'd0, rv); chk_eq("R6 interrupted unlock blocks start", rv[1], 0);
        wait_cyc(WRC + 2);
        array_byte(4'd5, rv); chk_eq("R6 array unchanged", rv, 8'h3C);
    endtask

    task automatic t_busy_ignores;
        int guard;
        start_write(4'd7, 8'h5A);
        wr(2'd0, 8'h05);
        rd(2'd0, rv);
        chk_eq("R4 busy kept after writing 0", rv[1], 1);
        chk_eq("R12 read ignored during write", rv[0], 0);
        wr(2'd1, 8'd2);
        wr(2'd2, 8'hFF);
        rd(2'd1, rv); chk_eq("R13 addr held", rv, 8'd7);
        rd(2'd2, rv); chk_eq("R13/R12 data held", rv, 8'h5A);
        guard = 0;
        rd(2'd0, rv);
        while (rv[1] && guard < 4 * WRC) begin
            @(negedge clk); guard++; rd(2'd0, rv);
        end
        array_byte(4'd7, rv); chk_eq("R13 array got held data", rv, 8'h5A);
    endtask

    task automatic t_ext_abort;
        @(negedge clk); wdone_clr = 1'b1;
        @(negedge clk); wdone_clr = 1'b0;
        chk_eq("R8 wdone cleared by software", wdone, 0);
        start_write(4'd9, 8'h11);
        wait_cyc(WRC + 1);
        start_write(4'd9, 8'h77);
        wait_cyc(5);
        ext_rst_n = 1'b0;
        @(negedge clk);
        ext_rst_n = 1'b1;
        rd(2'd0, rv); chk_eq("R9 ctrl after ext abort", rv, 8'h08);
        rd(2'd1, rv); chk_eq("R9 addr kept", rv, 8'd9);
        rd(2'd2, rv); chk_eq("R9 data kept", rv, 8'h77);
        wdone_clr = 1'b1; @(negedge clk); wdone_clr = 1'b0;
        wait_cyc(WRC);
        chk_eq("R9 no wdone after abort", wdone, 0);
        wr(2'd0, 8'h09);
        @(negedge clk);
        rd(2'd2, rv); chk_eq("R9 array not written", rv, 8'h11);
    endtask

    task automatic t_idle_warm;
        wr(2'd2, 8'h33);
        wr(2'd0, 8'h0C);
        @(negedge clk); wdt_rst_n = 1'b0;
        @(negedge clk); wdt_rst_n = 1'b1;
        rd(2'd0, rv); chk_eq("R10 idle warm reset ctrl", rv, 8'h08);
        rd(2'd2, rv); chk_eq("R10 data kept", rv, 8'h33);
        rd(2'd1, rv); chk_eq("R10 addr kept", rv, 8'd9);
    endtask

    task automatic t_abort_at_commit;
        start_write(4'd9, 8'h66);
        wait_cyc(WRC - 1);
        wdt_rst_n = 1'b0;
        @(negedge clk);
        wdt_rst_n = 1'b1;
        rd(2'd0, rv); chk_eq("R9 commit-edge abort ctrl", rv, 8'h08);
        chk_eq("R9 commit-edge abort wdone", wdone, 0);
        wr(2'd0, 8'h09);
        @(negedge clk);
        rd(2'd2, rv); chk_eq("R9 commit-edge array unchanged", rv, 8'h11);
    endtask

    task automatic t_clear_at_commit;
        start_write(4'd3, 8'h42);
        wait_cyc(WRC + 1);
        chk_eq("R8 wdone set first write", wdone, 1);
        start_write(4'd4, 8'h24);
        wait_cyc(WRC - 1);
        wdone_clr = 1'b1;
        @(negedge clk);
        wdone_clr = 1'b0;
        chk_eq("R8 commit beats clear", wdone, 1);
        array_byte(4'd4, rv); chk_eq("R7 second write stored", rv, 8'h24);
    endtask

    task automatic t_por;
        wr(2'd0, 8'h0C);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd(2'd0, rv); chk_eq("R11 por clears err and enable", rv, 8'h00);
        rd(2'd1, rv); chk_eq("R11 por clears addr", rv, 8'h00);
    endtask

    bit done_flag = 1'b0;

    initial begin
        wait_cyc(3);
        por_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_upper_bits();
        t_full_write();
        t_no_enable();
        t_broken_unlock();
        t_busy_ignores();
        t_ext_abort();
        t_idle_warm();
        t_abort_at_commit();
        t_clear_at_commit();
        t_por();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule